// File: doc/BRIEF.md
# Trap routing and vector generator

This block takes the machine state at the moment a trap is taken and decides which of five routes the trap follows. The routes are reset-style red entry, the error state, a guest-watchdog redirect into hyperprivileged mode, ordinary hyperprivileged entry and privileged entry. For the chosen route it computes the handler address and the address after it. The inputs are the current trap level, the red, hpriv and priv mode bits, the trap type, and the two handler base registers.

The block does not save any machine state. Its route code tells the surrounding pipeline which save sequence to run. The register logic around it captures the result when `req` pulses. That result stays on the outputs until the next request, and a one-cycle `vld` marks each new result. An error route also raises an error flag, which stays set until reset.

Top module: `trap_route_gen`

## Requirements
- R1: The current level is hyperprivileged when `hpriv` is 1, otherwise privileged when `priv` is 1, otherwise user. From user or privileged the trap goes to privileged level, and from hyperprivileged it stays hyperprivileged.
- R2: When `red` is 1, or `tl` equals MAX_TL-1, the route is red entry (code 2) and `tt_out` is 5. `pc` is 0xFFF0000000 ORed with the low 8 bits of (5 << 5), which gives 0xFFF00000A0. This case takes priority over every other route.
- R3: Otherwise, when `tl` is MAX_TL or above, the route is error (code 3). `tt_out` equals `tt`, and `pc` and `npc` are 0. `err_flag` goes to 1 in the same cycle as `vld` and stays at 1 until reset.
- R4: Otherwise, when `tl` is above MAX_PTL and the next level is privileged, the route is hyperprivileged entry (code 1) with `tt_out` = 2.
- R5: Otherwise, when the next level is hyperprivileged, or it is privileged and `tt` is at least 384, the route is hyperprivileged entry (code 1) and `tt_out` equals `tt`.
- R6: In every other case the route is privileged entry (code 0) and `tt_out` equals `tt`.
- R7: For hyperprivileged entry, `pc` is `htba` with bits 13:0 cleared, ORed with (`tt_out` << 5) masked to 14 bits.
- R8: For privileged entry, `pc` is `tba` with bits 14:0 cleared. Bit 14 is set when `tl`+1 is greater than 1. The result is ORed with (`tt_out` << 5) masked to 14 bits.
- R9: For every route except error, `npc` equals `pc` + 4.
- R10: The outputs are captured at the clock edge where `req` is 1, and `vld` is 1 in the following cycle only. While `req` is 0 the outputs hold their values.
- R11: After reset, `vld`, `err_flag`, `route`, `tt_out`, `pc` and `npc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Strobe to capture a routing result |
| tl | input | TL_W (3) | Current trap level |
| red | input | 1 | Red-state mode bit |
| hpriv | input | 1 | Hyperprivileged mode bit |
| priv | input | 1 | Privileged mode bit |
| tt | input | TT_W (9) | Trap type |
| htba | input | ADDR_W (64) | Hyperprivileged handler base |
| tba | input | ADDR_W (64) | Privileged handler base |
| vld | output | 1 | One-cycle pulse after each request |
| route | output | 2 | 0 privileged, 1 hyperprivileged, 2 red, 3 error |
| tt_out | output | TT_W (9) | Effective trap type |
| pc | output | ADDR_W (64) | Handler address |
| npc | output | ADDR_W (64) | Handler address plus 4 |
| err_flag | output | 1 | Sticky error indication |

## Verification
Several route conditions can be true for the same request, and the priority order decides the result. When `red` is set and `tl` is at the error level, red entry must win. When a non-hyperprivileged trap arrives above the privileged level limit with a type of 384 or more, the guest-watchdog redirect must win, so the type becomes 2 and the cutoff on the original type is ignored. The bench sweeps every trap level with every combination of mode bits and a set of trap types on both sides of 384, which reaches every such overlap. It compares route, type and vector against an arithmetic model. The error flag is tracked across the whole sweep, so a later non-error request shows whether the flag stayed set.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;
  typedef enum logic [1:0] {
    RT_PRIV = 2'd0,
    RT_HYP  = 2'd1,
    RT_RED  = 2'd2,
    RT_ERR  = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    LV_USER = 2'd0,
    LV_PRIV = 2'd1,
    LV_HYP  = 2'd2
  } lvl_e;

  function automatic lvl_e f_cur_level(input logic hp, input logic pv);
    if (hp) return LV_HYP;
    if (pv) return LV_PRIV;
    return LV_USER;
  endfunction

  function automatic lvl_e f_next_level(input lvl_e cur);
    return (cur == LV_HYP) ? LV_HYP : LV_PRIV;
  endfunction
endpackage

// File: rtl/trap_lvl_decide.sv
module trap_lvl_decide
  import trap_route_pkg::*;
#(
  parameter int TL_W       = 3,
  parameter int TT_W       = 9,
  parameter int MAX_TL     = 6,
  parameter int MAX_PTL    = 2,
  parameter int HYP_TT_CUT = 384,
  parameter int RED_TT     = 5,
  parameter int WDOG_TT    = 2
) (
  input  logic [TL_W-1:0] tl,
  input  logic            red,
  input  logic            hpriv,
  input  logic            priv,
  input  logic [TT_W-1:0] tt,
  output route_e          route,
  output logic [TT_W-1:0] eff_tt,
  output logic [TL_W:0]   vec_tl
);
  localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_ERR  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_PMAX = TL_W'(MAX_PTL);
  localparam logic [TT_W-1:0] TT_CUT  = TT_W'(HYP_TT_CUT);

  lvl_e cur_lvl, nxt_lvl;
  logic hit_red, hit_err, hit_wdog, hit_hyp;

  always_comb begin
    cur_lvl  = f_cur_level(hpriv, priv);
    nxt_lvl  = f_next_level(cur_lvl);
    hit_red  = red || (tl == TL_RED);
    hit_err  = (tl >= TL_ERR);
    hit_wdog = (tl > TL_PMAX) && (nxt_lvl == LV_PRIV);
    hit_hyp  = (nxt_lvl == LV_HYP) || ((nxt_lvl == LV_PRIV) && (tt >= TT_CUT));
    vec_tl   = {1'b0, tl} + (TL_W+1)'(1);
    eff_tt   = tt;
    if (hit_red) begin
      route  = RT_RED;
      eff_tt = TT_W'(RED_TT);
    end else if (hit_err) begin
      route  = RT_ERR;
    end else if (hit_wdog) begin
      route  = RT_HYP;
      eff_tt = TT_W'(WDOG_TT);
    end else if (hit_hyp) begin
      route  = RT_HYP;
    end else begin
      route  = RT_PRIV;
    end
  end
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_route_pkg::*;
#(
  parameter int          ADDR_W    = 64,
  parameter int          TT_W      = 9,
  parameter int          TL_W      = 3,
  parameter int          VEC_ALIGN = 14,
  parameter logic [63:0] RED_BASE  = 64'h0000_00FF_F000_0000
) (
  input  route_e            route,
  input  logic [TT_W-1:0]   eff_tt,
  input  logic [TL_W:0]     vec_tl,
  input  logic [ADDR_W-1:0] htba,
  input  logic [ADDR_W-1:0] tba,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc
);
  localparam logic [ADDR_W-1:0] LOW_MASK  = (ADDR_W'(1) << VEC_ALIGN) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PLOW_MASK = (ADDR_W'(1) << (VEC_ALIGN + 1)) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TL_BIT    = ADDR_W'(1) << VEC_ALIGN;
  localparam logic [ADDR_W-1:0] RED_MASK  = ADDR_W'(8'hFF);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(4);

  function automatic logic [ADDR_W-1:0] f_slot(input logic [TT_W-1:0] t);
    return ADDR_W'({t, 5'b00000});
  endfunction

  function automatic logic [ADDR_W-1:0] f_red_vec(input logic [TT_W-1:0] t);
    return ADDR_W'(RED_BASE) | (f_slot(t) & RED_MASK);
  endfunction

  function automatic logic [ADDR_W-1:0] f_hyp_vec(input logic [ADDR_W-1:0] base,
                                                  input logic [TT_W-1:0] t);
    return (base & ~LOW_MASK) | (f_slot(t) & LOW_MASK);
  endfunction

  function automatic logic [ADDR_W-1:0] f_priv_vec(input logic [ADDR_W-1:0] base,
                                                   input logic [TT_W-1:0] t,
                                                   input logic [TL_W:0] lvl);
    return (base & ~PLOW_MASK) | ((lvl > (TL_W+1)'(1)) ? TL_BIT : '0)
           | (f_slot(t) & LOW_MASK);
  endfunction

  always_comb begin
    unique case (route)
      RT_RED:  pc = f_red_vec(eff_tt);
      RT_HYP:  pc = f_hyp_vec(htba, eff_tt);
      RT_PRIV: pc = f_priv_vec(tba, eff_tt, vec_tl);
      default: pc = '0;
    endcase
    npc = (route == RT_ERR) ? '0 : pc + STEP;
  end
endmodule

// File: rtl/trap_route_gen.sv
module trap_route_gen
  import trap_route_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int TT_W    = 9,
  parameter int TL_W    = 3,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [TL_W-1:0]   tl,
  input  logic              red,
  input  logic              hpriv,
  input  logic              priv,
  input  logic [TT_W-1:0]   tt,
  input  logic [ADDR_W-1:0] htba,
  input  logic [ADDR_W-1:0] tba,
  output logic              vld,
  output logic [1:0]        route,
  output logic [TT_W-1:0]   tt_out,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc,
  output logic              err_flag
);
  route_e            route_d;
  logic [TT_W-1:0]   tt_d;
  logic [TL_W:0]     vec_tl;
  logic [ADDR_W-1:0] pc_d, npc_d;
  logic              err_hit;

  trap_lvl_decide #(
    .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
  ) u_decide (
    .tl(tl), .red(red), .hpriv(hpriv), .priv(priv), .tt(tt),
    .route(route_d), .eff_tt(tt_d), .vec_tl(vec_tl)
  );

  trap_vec_gen #(
    .ADDR_W(ADDR_W), .TT_W(TT_W), .TL_W(TL_W)
  ) u_vec (
    .route(route_d), .eff_tt(tt_d), .vec_tl(vec_tl),
    .htba(htba), .tba(tba), .pc(pc_d), .npc(npc_d)
  );

  assign err_hit = req && (route_d == RT_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld      <= 1'b0;
      route    <= 2'd0;
      tt_out   <= '0;
      pc       <= '0;
      npc      <= '0;
      err_flag <= 1'b0;
    end else begin
      vld <= req;
      if (req) begin
        route  <= route_d;
        tt_out <= tt_d;
        pc     <= pc_d;
        npc    <= npc_d;
      end
      if (err_hit) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/trap_route_chk.sv
module trap_route_chk #(
  parameter int ADDR_W = 64,
  parameter int TT_W   = 9,
  parameter int TL_W   = 3,
  parameter int MAX_TL = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [TL_W-1:0]   tl,
  input logic              red,
  input logic              hpriv,
  input logic              vld,
  input logic [1:0]        route,
  input logic [TT_W-1:0]   tt_out,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] npc,
  input logic              err_flag
);
  localparam logic [TL_W-1:0] TL_RED = TL_W'(MAX_TL - 1);

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req |=> vld); // R10
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req |=> !vld); // R10
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(pc) && $stable(route) && $stable(tt_out))); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_flag |=> err_flag); // R3
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && route == 2'd3) |-> err_flag); // R3
  AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && route != 2'd3) |-> (npc == pc + ADDR_W'(4))); // R9
  AST_RED_TT: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && route == 2'd2) |-> (tt_out == TT_W'(5))); // R2
  AST_RED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (red || tl == TL_RED)) |=> (route == 2'd2)); // R2
  AST_HYP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hpriv && !red && tl < TL_RED) |=> (route == 2'd1)); // R5
endmodule

bind trap_route_gen trap_route_chk #(
  .ADDR_W(ADDR_W), .TT_W(TT_W), .TL_W(TL_W), .MAX_TL(MAX_TL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .tl(tl), .red(red), .hpriv(hpriv),
  .vld(vld), .route(route), .tt_out(tt_out), .pc(pc), .npc(npc),
  .err_flag(err_flag)
);

// File: tb/test_trap_route_gen.sv
module test_trap_route_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  tl = '0;
  logic        red = 1'b0, hpriv = 1'b0, priv = 1'b0;
  logic [8:0]  tt = '0;
  logic [63:0] htba = '0, tba = '0;
  logic        vld, err_flag;
  logic [1:0]  route;
  logic [8:0]  tt_out;
  logic [63:0] pc, npc;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_route_gen i_trap_route_gen (
    .clk(clk), .rst_n(rst_n), .req(req), .tl(tl), .red(red), .hpriv(hpriv),
    .priv(priv), .tt(tt), .htba(htba), .tba(tba), .vld(vld), .route(route),
    .tt_out(tt_out), .pc(pc), .npc(npc), .err_flag(err_flag)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [63:0] tt_list [6] = '{64'd0, 64'd5, 64'h24, 64'd383, 64'd384, 64'd511};
  logic [63:0] hb_list [2] = '{64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF};
  logic [63:0] pb_list [2] = '{64'h0F0F_0000_5555_AAAA, 64'h8000_0000_0000_7FFF};

  initial begin
    logic exp_err;
    exp_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 vld", {63'd0, vld}, 64'd0);
    chk("R11 err_flag", {63'd0, err_flag}, 64'd0);
    chk("R11 pc", pc, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 route", {62'd0, route}, 64'd0);
    chk("R11 npc", npc, 64'd0);

    for (int b = 0; b < 2; b++) begin
      for (int l = 0; l < 8; l++) begin
        for (int m = 0; m < 8; m++) begin
          for (int k = 0; k < 6; k++) begin
            int          er;
            int          et;
            logic [63:0] ep;
            string       ctag;
            htba  = hb_list[b];
            tba   = pb_list[b];
            tl    = 3'(l);
            red   = m[2];
            hpriv = m[1];
            priv  = m[0];
            tt    = 9'(tt_list[k]);
            et    = int'(tt_list[k]);
            // model: user and privileged both trap into privileged (R1)
            if (red || l == 5) begin
              er = 2; et = 5; ctag = "R2";
              ep = 64'hFF_F000_0000 + 64'((et * 32) % 256);
            end else if (l >= 6) begin
              er = 3; ctag = "R3"; ep = 0;
            end else if (l > 2 && !hpriv) begin
              er = 1; et = 2; ctag = "R4 R7";
              ep = (htba / 16384) * 16384 + 64'((et * 32) % 16384);
            end else if (hpriv || et >= 384) begin
              er = 1; ctag = "R5 R7";
              ep = (htba / 16384) * 16384 + 64'((et * 32) % 16384);
            end else begin
              er = 0; ctag = "R6 R8";
              ep = (tba / 32768) * 32768 + ((l + 1 > 1) ? 64'd16384 : 64'd0)
                   + 64'((et * 32) % 16384);
            end
            if (er == 3) exp_err = 1'b1;
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            chk("R10 vld pulse", {63'd0, vld}, 64'd1);
            chk($sformatf("R1 %s route tl=%0d m=%0d", ctag, l, m), {62'd0, route}, 64'(er));
            chk($sformatf("%s tt_out", ctag), {55'd0, tt_out}, 64'(et));
            chk($sformatf("%s pc", ctag), pc, ep);
            chk("R9 npc", npc, (er == 3) ? 64'd0 : ep + 64'd4);
            chk("R3 err_flag", {63'd0, err_flag}, {63'd0, exp_err});
            tt = ~tt;
            tl = ~tl;
            @(negedge clk);
            chk("R10 vld drop", {63'd0, vld}, 64'd0);
            chk("R10 hold pc", pc, ep);
          end
        end
      end
    end

    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 err_flag cleared", {63'd0, err_flag}, 64'd0);
    chk("R11 pc cleared", pc, 64'd0);
    chk("R11 tt_out cleared", {55'd0, tt_out}, 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule